// File: doc/BRIEF.md
# Coprocessor Response Polling Trace Controller

This controller sits on the main-processor side of a coprocessor link. For the length of one coprocessor instruction it decides how often to read the coprocessor's response register. It also decides when the coprocessor can be released to finish on its own, and whether the instruction ends with a trace exception request. Each response word is presented as separate flags: come-again (CA), pass-flag (PF), interrupt-allowed (IA) and direction (DR). A primitive type field comes with them. The controller reads these fields and does nothing else with the word.

Two trace modes exist. In every-instruction tracing, a general-category instruction must not be released early. Polling therefore continues past CA=0 until the coprocessor reports a finished null primitive, or until a post-instruction exception primitive has been handled. In change-of-flow tracing, the instruction traces only if a status-register/scanPC transfer primitive with DR=1 arrived during it. The coprocessor may still be running when that trace is raised. Between two reads, a pending interrupt may be serviced only if the last primitive allowed it.

Top module: `cprt_ctrl`

## Requirements
- R1: While reset is asserted, and in the cycle after it is released, `rd_req`, `done`, `trace_req` and `irq_window` are all 0.
- R2: A `start` accepted while idle makes `rd_req` high for exactly one cycle, in the next cycle. Every read is a one-cycle pulse. No further read is issued until a response has been taken with `rsp_valid`.
- R3: Unless every-instruction tracing of a general-category instruction is in effect, the instruction finishes with `done` after the first response whose CA is 0.
- R4: With trace mode 2'b10 and `start_gen`=1, polling continues past CA=0. It finishes only on a null primitive (type 0) with CA=0 and PF=1. A null primitive with PF=0 causes another read.
- R5: In the same mode, a post-instruction exception primitive (type 2) stops the reads. `done` follows only after `exc_done` has been pulsed.
- R6: `irq_window` is high for one cycle between two reads, and only when `irq_pending` is 1 and the IA bit of the last primitive was 1. It is never high at any other time.
- R7: `trace_req`, when issued, is a one-cycle pulse in the cycle after `done`. There is at most one per instruction.
- R8: Trace mode 2'b10 always traces. Mode 2'b01 traces only if a primitive of type 1 (status-register/scanPC transfer) with DR=1 was read during the instruction. DR on any other type has no effect. Modes 2'b00 and 2'b11 never trace.
- R9: For a non-general instruction (`start_gen`=0), polling ends at CA=0 even in mode 2'b10. The trace is still requested after `done` in that mode.
- R10: `start` is ignored while an instruction is in progress.
- R11: The trace mode and the category are sampled at the accepted `start`. Later changes to these inputs have no effect on that instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trace_mode | input | 2 | Trace mode: 00 off, 01 change of flow, 10 every instruction, 11 off |
| start | input | 1 | Begin a coprocessor instruction |
| start_gen | input | 1 | 1 = general category, 0 = save/restore/conditional |
| rsp_valid | input | 1 | Response word present |
| rsp_ca | input | 1 | Come-again flag |
| rsp_pf | input | 1 | Pass flag of the null primitive |
| rsp_ia | input | 1 | Interrupts allowed before the next read |
| rsp_dr | input | 1 | Direction flag |
| rsp_type | input | TYPE_W | Primitive type: 0 null, 1 SR/scanPC transfer, 2 post-instruction exception |
| exc_done | input | 1 | Exception processing for a post-instruction primitive has finished |
| irq_pending | input | 1 | An interrupt is waiting |
| rd_req | output | 1 | Read the response register |
| done | output | 1 | Instruction finished; coprocessor released |
| trace_req | output | 1 | Trace exception request |
| irq_window | output | 1 | Interrupt may be serviced now |

## Verification
The checker watches the pulse shapes on every cycle. It confirms that reads, `done` and `irq_window` are one-cycle pulses and never overlap. It confirms that an accepted start is followed by a read, that an interrupt window is followed by a read, and that `trace_req` appears only right after `done`. The rest can only be shown by the bench's scenarios against a model of the primitive stream. That covers how many reads an instruction takes in each mode and category, the wait for `exc_done`, the DR filtering by type, and the mode being held from the start.

// File: rtl/cprt_pkg.sv
package cprt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_READ = 3'd1,
    ST_WAIT = 3'd2,
    ST_GAP  = 3'd3,
    ST_EXC  = 3'd4,
    ST_DONE = 3'd5
  } state_e;

  typedef enum logic [1:0] {
    TM_OFF   = 2'b00,
    TM_FLOW  = 2'b01,
    TM_EVERY = 2'b10,
    TM_RSVD  = 2'b11
  } tmode_e;

  typedef struct packed {
    logic fin;
    logic exc;
    logic dr_hit;
  } verdict_t;
endpackage

// File: rtl/cprt_decode.sv
module cprt_decode
  import cprt_pkg::*;
#(
  parameter int TYPE_W = 4,
  parameter int NULL_CODE = 0,
  parameter int XFER_CODE = 1,
  parameter int PEXC_CODE = 2
) (
  input  logic              full_trace,
  input  logic              ca,
  input  logic              pf,
  input  logic              dr,
  input  logic [TYPE_W-1:0] typ,
  output verdict_t          verdict
);
  localparam logic [TYPE_W-1:0] NullC = TYPE_W'(NULL_CODE);
  localparam logic [TYPE_W-1:0] XferC = TYPE_W'(XFER_CODE);
  localparam logic [TYPE_W-1:0] PexcC = TYPE_W'(PEXC_CODE);

  logic is_null, is_xfer, is_pexc;

  always_comb begin
    is_null = (typ == NullC);
    is_xfer = (typ == XferC);
    is_pexc = (typ == PexcC);
    verdict.dr_hit = is_xfer & dr;
    if (full_trace) begin
      // completion must be confirmed by the coprocessor itself
      verdict.fin = is_null & ~ca & pf;
      verdict.exc = is_pexc & ~(is_null & ~ca & pf);
    end else begin
      verdict.fin = ~ca;
      verdict.exc = 1'b0;
    end
  end
endmodule

// File: rtl/cprt_fsm.sv
module cprt_fsm
  import cprt_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     start,
  input  logic     rsp_valid,
  input  logic     rsp_ia,
  input  verdict_t verdict,
  input  logic     exc_done,
  input  logic     irq_pending,
  output state_e   state,
  output logic     start_acc,
  output logic     rsp_take,
  output logic     rd_req,
  output logic     done,
  output logic     irq_window
);
  state_e state_q, state_d;
  logic   ia_q, ia_d, ia_en;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start) state_d = ST_READ;
      ST_READ: state_d = ST_WAIT;
      ST_WAIT: begin
        if (rsp_valid) begin
          if (verdict.fin)      state_d = ST_DONE;
          else if (verdict.exc) state_d = ST_EXC;
          else                  state_d = ST_GAP;
        end
      end
      ST_GAP:  state_d = ST_READ;
      ST_EXC:  if (exc_done) state_d = ST_DONE;
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    rsp_take  = (state_q == ST_WAIT) & rsp_valid;
    start_acc = (state_q == ST_IDLE) & start;
    ia_en     = rsp_take;
    ia_d      = rsp_ia;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ia_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      if (ia_en) ia_q <= ia_d;
    end
  end

  always_comb begin
    state      = state_q;
    rd_req     = (state_q == ST_READ);
    done       = (state_q == ST_DONE);
    irq_window = (state_q == ST_GAP) & irq_pending & ia_q;
  end
endmodule

// File: rtl/cprt_trace.sv
module cprt_trace
  import cprt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_acc,
  input  logic [1:0] mode_in,
  input  logic       gen_in,
  input  logic       rsp_take,
  input  logic       dr_hit,
  input  logic       done,
  output logic       full_trace,
  output logic       trace_req
);
  tmode_e mode_q;
  logic   gen_q, dr_seen_q, trace_q;
  logic   dr_seen_d, dr_en, due;

  always_comb begin
    dr_en     = start_acc | (rsp_take & dr_hit);
    dr_seen_d = ~start_acc;
    full_trace = (mode_q == TM_EVERY) & gen_q;
    unique case (mode_q)
      TM_EVERY: due = 1'b1;
      TM_FLOW:  due = dr_seen_q;
      default:  due = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= TM_OFF;
      gen_q     <= 1'b0;
      dr_seen_q <= 1'b0;
      trace_q   <= 1'b0;
    end else begin
      if (start_acc) begin
        mode_q <= tmode_e'(mode_in);
        gen_q  <= gen_in;
      end
      if (dr_en) dr_seen_q <= dr_seen_d;
      trace_q <= done & due;
    end
  end

  assign trace_req = trace_q;
endmodule

// File: rtl/cprt_ctrl.sv
module cprt_ctrl
  import cprt_pkg::*;
#(
  parameter int TYPE_W = 4,
  parameter int NULL_CODE = 0,
  parameter int XFER_CODE = 1,
  parameter int PEXC_CODE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        trace_mode,
  input  logic              start,
  input  logic              start_gen,
  input  logic              rsp_valid,
  input  logic              rsp_ca,
  input  logic              rsp_pf,
  input  logic              rsp_ia,
  input  logic              rsp_dr,
  input  logic [TYPE_W-1:0] rsp_type,
  input  logic              exc_done,
  input  logic              irq_pending,
  output logic              rd_req,
  output logic              done,
  output logic              trace_req,
  output logic              irq_window
);
  verdict_t verdict;
  state_e   state;
  logic     full_trace, start_acc, rsp_take;

  cprt_decode #(
    .TYPE_W(TYPE_W), .NULL_CODE(NULL_CODE),
    .XFER_CODE(XFER_CODE), .PEXC_CODE(PEXC_CODE)
  ) u_decode (
    .full_trace(full_trace), .ca(rsp_ca), .pf(rsp_pf), .dr(rsp_dr),
    .typ(rsp_type), .verdict(verdict)
  );

  cprt_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start), .rsp_valid(rsp_valid),
    .rsp_ia(rsp_ia), .verdict(verdict), .exc_done(exc_done),
    .irq_pending(irq_pending), .state(state), .start_acc(start_acc),
    .rsp_take(rsp_take), .rd_req(rd_req), .done(done),
    .irq_window(irq_window)
  );

  cprt_trace u_trace (
    .clk(clk), .rst_n(rst_n), .start_acc(start_acc), .mode_in(trace_mode),
    .gen_in(start_gen), .rsp_take(rsp_take), .dr_hit(verdict.dr_hit),
    .done(done), .full_trace(full_trace), .trace_req(trace_req)
  );
endmodule

// File: rtl/cprt_ctrl_chk.sv
module cprt_ctrl_chk
  import cprt_pkg::*;
(
  input logic   clk,
  input logic   rst_n,
  input logic   start,
  input state_e state,
  input logic   rd_req,
  input logic   done,
  input logic   trace_req,
  input logic   irq_window,
  input logic   irq_pending
);
  assert_read_after_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && state == ST_IDLE) |=> rd_req);
  assert_read_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> !rd_req);
  assert_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_req, done, irq_window}));
  assert_window_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_window |-> irq_pending);
  assert_window_then_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_window |=> rd_req);
  assert_trace_after_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    trace_req |-> $past(done));
  assert_trace_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    trace_req |=> !trace_req);
  assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind cprt_ctrl cprt_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .state(state), .rd_req(rd_req),
  .done(done), .trace_req(trace_req), .irq_window(irq_window),
  .irq_pending(irq_pending)
);

// File: tb/tb_cprt_ctrl.sv
module tb_cprt_ctrl;
  logic       clk, rst_n;
  logic [1:0] trace_mode;
  logic       start, start_gen, rsp_valid, rsp_ca, rsp_pf, rsp_ia, rsp_dr;
  logic [3:0] rsp_type;
  logic       exc_done, irq_pending;
  logic       rd_req, done, trace_req, irq_window;

  int n_checks = 0;
  int n_fail = 0;
  int cyc = 0;

  logic [3:0] p_type [8];
  logic       p_ca [8], p_pf [8], p_ia [8], p_dr [8];
  int         n_p;

  cprt_ctrl dut (
    .clk(clk), .rst_n(rst_n), .trace_mode(trace_mode), .start(start),
    .start_gen(start_gen), .rsp_valid(rsp_valid), .rsp_ca(rsp_ca),
    .rsp_pf(rsp_pf), .rsp_ia(rsp_ia), .rsp_dr(rsp_dr), .rsp_type(rsp_type),
    .exc_done(exc_done), .irq_pending(irq_pending), .rd_req(rd_req),
    .done(done), .trace_req(trace_req), .irq_window(irq_window)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_fail = n_fail + 1;
      n_checks = n_checks + 1;
      $display("FAIL watchdog: act %0d cycles exp fewer than 150000", cyc);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: act %0d exp %0d", req, what, act, exp);
    end
  endtask

  task automatic set_p(input int i, input int t, input bit ca, input bit pf,
                       input bit ia, input bit dr);
    p_type[i] = 4'(t); p_ca[i] = ca; p_pf[i] = pf; p_ia[i] = ia; p_dr[i] = dr;
  endtask

  task automatic model(input logic [1:0] m, input bit g, input bit irqp,
                       output int reads, output bit trc, output bit exc,
                       output int win);
    bit full, dr;
    full = (m == 2'b10) && g;
    dr = 0; reads = 0; exc = 0; win = 0;
    for (int i = 0; i < n_p; i++) begin
      bit fin, ex;
      reads++;
      if (p_type[i] == 4'd1 && p_dr[i]) dr = 1;
      fin = full ? (p_type[i] == 4'd0 && !p_ca[i] && p_pf[i]) : !p_ca[i];
      ex  = full && p_type[i] == 4'd2 && !fin;
      if (fin) break;
      if (ex) begin exc = 1; break; end
      if (irqp && p_ia[i]) win++;
    end
    trc = (m == 2'b10) || (m == 2'b01 && dr);
  endtask

  // runs one instruction against the current script
  task automatic run(input logic [1:0] m, input bit g, input bit irqp,
                     input bit scramble, input bit poke_start, input string tag);
    int  e_reads, e_win, reads, win, idx, guard;
    bit  e_trc, e_exc, exc_sent, timed_out;
    model(m, g, irqp, e_reads, e_trc, e_exc, e_win);
    reads = 0; win = 0; idx = 0; guard = 0; exc_sent = 0; timed_out = 0;
    @(negedge clk);
    trace_mode = m; start_gen = g; irq_pending = irqp; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (scramble) begin            // R11: inputs move after start
      trace_mode = 2'($urandom);
      start_gen = 1'($urandom);
    end
    while (1) begin
      if (irq_window) win++;
      if (done) break;
      if (guard > 300) begin timed_out = 1; break; end
      if (rd_req) begin
        int dly;
        reads++;
        dly = $urandom % 3;
        @(negedge clk);
        chk(!rd_req, "R2", "read pulse width", int'(rd_req), 0);
        if (poke_start) start = 1'b1;   // R10: start while busy
        repeat (dly) @(negedge clk);
        start = 1'b0;
        chk(!rd_req && !done, "R2", "no read before response",
            int'(rd_req), 0);
        rsp_valid = 1'b1;
        rsp_type = p_type[idx < n_p ? idx : n_p-1];
        rsp_ca = p_ca[idx < n_p ? idx : n_p-1];
        rsp_pf = p_pf[idx < n_p ? idx : n_p-1];
        rsp_ia = p_ia[idx < n_p ? idx : n_p-1];
        rsp_dr = p_dr[idx < n_p ? idx : n_p-1];
        idx++;
        @(negedge clk);
        rsp_valid = 1'b0;
        rsp_type = 4'($urandom); rsp_ca = 1'($urandom);
        rsp_pf = 1'($urandom); rsp_dr = 1'($urandom); rsp_ia = 1'($urandom);
        guard++;
      end else begin
        if (e_exc && idx == e_reads && !exc_sent) begin
          repeat (2) begin
            chk(!done && !rd_req, "R5", "held until exc_done",
                int'(done | rd_req), 0);
            @(negedge clk);
          end
          exc_done = 1'b1;
          @(negedge clk);
          exc_done = 1'b0;
          exc_sent = 1;
        end else begin
          @(negedge clk);
        end
        guard++;
      end
    end
    chk(!timed_out, tag, "instruction finished", int'(timed_out), 0);
    chk(reads == e_reads, tag, "read count", reads, e_reads);
    chk(win == e_win, "R6", "interrupt windows", win, e_win);
    @(negedge clk);
    chk(trace_req == e_trc, "R8", "trace after done", int'(trace_req),
        int'(e_trc));
    chk(!rd_req, "R10", "idle after done", int'(rd_req), 0);
    @(negedge clk);
    chk(!trace_req, "R7", "single trace pulse", int'(trace_req), 0);
    chk(!rd_req, "R10", "no stray read", int'(rd_req), 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; start = 0; start_gen = 0; trace_mode = 0; rsp_valid = 0;
    rsp_ca = 0; rsp_pf = 0; rsp_ia = 0; rsp_dr = 0; rsp_type = 0;
    exc_done = 0; irq_pending = 0;
    repeat (3) @(negedge clk);
    chk({rd_req, done, trace_req, irq_window} == 4'b0, "R1", "outputs in reset",
        int'({rd_req, done, trace_req, irq_window}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({rd_req, done, trace_req, irq_window} == 4'b0, "R1", "outputs after reset",
        int'({rd_req, done, trace_req, irq_window}), 0);

    // R3: tracing off, ends at first CA=0 even with PF=0
    n_p = 3; set_p(0, 5, 1, 0, 0, 0); set_p(1, 0, 0, 0, 0, 0); set_p(2, 0, 0, 1, 0, 0);
    run(2'b00, 1, 0, 0, 0, "R3");
    // R4: every-instruction, busy nulls repeat the read
    n_p = 3; set_p(0, 0, 0, 0, 0, 0); set_p(1, 0, 0, 0, 0, 0); set_p(2, 0, 0, 1, 0, 0);
    run(2'b10, 1, 0, 0, 0, "R4");
    // R5: post-instruction exception primitive
    n_p = 3; set_p(0, 5, 1, 0, 0, 0); set_p(1, 2, 0, 0, 0, 0); set_p(2, 0, 0, 1, 0, 0);
    run(2'b10, 1, 0, 0, 0, "R5");
    // R8: change of flow with DR on transfer primitive
    n_p = 2; set_p(0, 1, 1, 0, 0, 1); set_p(1, 0, 0, 0, 0, 0);
    run(2'b01, 1, 0, 0, 0, "R8");
    // R8: DR on another type is ignored
    n_p = 2; set_p(0, 5, 1, 0, 0, 1); set_p(1, 0, 0, 0, 0, 1);
    run(2'b01, 1, 0, 0, 0, "R8");
    // R8: reserved mode behaves like off
    n_p = 3; set_p(0, 0, 0, 0, 0, 0); set_p(1, 1, 0, 0, 0, 1); set_p(2, 0, 0, 1, 0, 0);
    run(2'b11, 1, 0, 0, 0, "R8");
    // R9: non-general category in every-instruction mode
    n_p = 2; set_p(0, 0, 0, 0, 0, 0); set_p(1, 0, 0, 1, 0, 0);
    run(2'b10, 0, 0, 0, 0, "R9");
    // R6: interrupt windows follow IA
    n_p = 4; set_p(0, 0, 0, 0, 1, 0); set_p(1, 0, 0, 0, 0, 0);
    set_p(2, 0, 1, 0, 1, 0); set_p(3, 0, 0, 1, 1, 0);
    run(2'b10, 1, 1, 0, 0, "R6");
    run(2'b10, 1, 0, 0, 0, "R6");
    // R10: start while busy
    n_p = 3; set_p(0, 0, 0, 0, 0, 0); set_p(1, 0, 0, 0, 0, 0); set_p(2, 0, 0, 1, 0, 0);
    run(2'b10, 1, 0, 0, 1, "R10");
    // R11: mode and category changed right after start
    run(2'b10, 1, 0, 1, 0, "R11");
    run(2'b00, 0, 0, 1, 0, "R11");

    for (int k = 0; k < 200; k++) begin
      logic [1:0] m;
      int sel;
      n_p = 1 + ($urandom % 7);
      for (int i = 0; i < n_p - 1; i++) begin
        sel = $urandom % 4;
        set_p(i, sel == 3 ? 5 : sel, 1'($urandom), 1'($urandom),
              1'($urandom), 1'($urandom));
      end
      set_p(n_p - 1, 0, 0, 1, 1'($urandom), 1'($urandom));
      m = 2'($urandom);
      run(m, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
          m == 2'b10 ? "R4" : "R3");
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule